// File: doc/BRIEF.md
# Standard-Definition Video Word Encoder

This block sits in front of a serializer in a standard-definition serial digital video transmitter. It takes one 10-bit word per clock and produces one registered 10-bit word for the serializer. In video mode it flags timing-reference codes and can optionally clean the two low bits of near-reference codes. Each word is then scrambled by a self-synchronising scrambler and NRZI coded, or it bypasses both stages.

In broadcast-data mode the block stops coding. It captures a word only when an active-low strobe asks for one, either for the current edge or for the next edge, and forwards that word unchanged. The one exception is the top bit, which carries a violation request that the serializer uses to emit an invalid symbol. When no strobe is given, the output holds its last value.

Every path has the same latency: an input register followed by an output register. A synchronous reset clears the scrambler and NRZI history and zeroes the output.

Top module: `sdi_word_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `dataOut` = 0x000 and `trsDetN` = 1, and the scrambler and NRZI history are cleared, so the first coded word after reset behaves as if all history bits were zero.
- R2: In video mode a word sampled on `dataIn` at edge k appears, coded or bypassed, on `dataOut` after edge k+1.
- R3: In video mode `trsDetN` is low after edge k exactly when the word sampled at edge k is in 0x000–0x003 or 0x3FC–0x3FF, that is, when bits 9:2 are all zero or all one. It is high after every other word.
- R4: While `videoMode` is low at an edge, `trsDetN` is high after that edge.
- R5: In video mode with `filterEnN` low, words 0x000–0x003 are replaced by 0x000 and words 0x3FC–0x3FF by 0x3FF before scrambling. With `filterEnN` high, words reach the scrambler unchanged.
- R6: The scrambler is self-synchronising with generator x^9 + x^4 + 1. It processes bit 0 first and bit 9 last, each scrambled bit being the data bit XOR the scrambled bits 4 and 9 positions earlier. Its history carries across words.
- R7: Each output bit is the XOR of its scrambled bit and the previous NRZI output bit. The previous bit for bit 0 is bit 9 of the last coded word.
- R8: In video mode with `bypass` high, `dataOut` equals the sampled word, unfiltered. Scrambler and NRZI history do not advance for that word.
- R9: In broadcast mode (`videoMode` low), `latchNowN` low at edge k captures the word at edge k, and it appears on `dataOut` after edge k+1 with bits 8:0 unchanged.
- R10: In broadcast mode, `latchNextN` low at edge k captures the word present at edge k+1, not the one at edge k. That word appears after edge k+2.
- R11: In broadcast mode, when no word is captured, `dataOut` holds its value.
- R12: In broadcast mode, output bit 9 equals input bit 9 AND `violEn`, with both sampled at the capture edge. With `violEn` low, bit 9 is forced to 0.
- R13: `bypass` and `filterEnN` have no effect in broadcast mode. Scrambler and NRZI history are held while in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 10 | Parallel input word |
| videoMode | input | 1 | 1 = video coding mode, 0 = broadcast-data mode |
| latchNowN | input | 1 | Active-low strobe: capture the word at this edge (broadcast mode) |
| latchNextN | input | 1 | Active-low strobe: capture the word at the next edge (broadcast mode) |
| bypass | input | 1 | Video mode: skip scrambler and NRZI |
| filterEnN | input | 1 | Video mode: active-low enable of the reference-code low-bit filter |
| violEn | input | 1 | Broadcast mode: allow input bit 9 through as violation request |
| dataOut | output | 10 | Registered output word |
| trsDetN | output | 1 | Active-low reference-code detect, aligned with the input register |

## Verification
The hardest state to reach from the ports is a scrambler history carried across a stretch of broadcast words and bypassed words. A wrong hold or advance shows only on the next coded word, and only as a shifted bit pattern. The stimulus runs a long video stream that mixes filtered, unfiltered and bypassed words against a bit-serial model. It then switches to broadcast mode, exercises both strobes and the violation bit, and returns to video. The first coded word after the return must match a model whose history was frozen across the gap. The deferred strobe is checked by changing the input word between the strobe edge and the capture edge.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;

  // Strobes presented to the datapath for the input-register edge
  typedef struct packed {
    logic load;    // capture dataIn into the input register
    logic video;   // captured word belongs to video mode
  } inStrobe_t;

  // Strobes that travel alongside the input register to the output stage
  typedef struct packed {
    logic valid;   // input register holds a new word
    logic video;   // word is coded in video mode
    logic bypass;  // skip scrambler and NRZI
    logic filtOn;  // apply reference-code low-bit filter
    logic violOn;  // broadcast: allow bit 9 through
  } outStrobe_t;

endpackage

// File: rtl/sdi_enc_ctrl.sv
module sdi_enc_ctrl
  import sdi_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       videoMode,
  input  logic       latchNowN,
  input  logic       latchNextN,
  input  logic       bypass,
  input  logic       filterEnN,
  input  logic       violEn,
  output inStrobe_t  inNow,
  output outStrobe_t stage1
);

  logic pendNext;

  // A deferred capture request, armed only in broadcast mode
  always_ff @(posedge clk) begin
    if (rst) pendNext <= 1'b0;
    else     pendNext <= !videoMode && !latchNextN;
  end

  always_comb begin
    inNow.load  = videoMode || !latchNowN || pendNext;
    inNow.video = videoMode;
  end

  // Mode qualifiers are folded in here so the datapath never sees a
  // broadcast-only or video-only control in the wrong mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
    end else begin
      stage1.valid  <= inNow.load;
      stage1.video  <= videoMode;
      stage1.bypass <= videoMode && bypass;
      stage1.filtOn <= videoMode && !filterEnN;
      stage1.violOn <= !videoMode && violEn;
    end
  end

endmodule

// File: rtl/sdi_enc_scrnrzi.sv
module sdi_enc_scrnrzi #(
  parameter int WORD_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int TAP_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] wordOut
);

  logic [SCR_LEN-1:0] scrState;
  logic               nrzState;

  // hist[i] is the scrambled-bit history seen by bit i (bit 0 = newest)
  logic [SCR_LEN-1:0] hist [0:WORD_W];
  logic               nrz  [0:WORD_W];
  logic [WORD_W-1:0]  scrBit;

  assign hist[0] = scrState;
  assign nrz[0]  = nrzState;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign scrBit[i]   = wordIn[i] ^ hist[i][TAP_POS-1] ^ hist[i][SCR_LEN-1];
    assign hist[i+1]   = {hist[i][SCR_LEN-2:0], scrBit[i]};
    assign nrz[i+1]    = nrz[i] ^ scrBit[i];
    assign wordOut[i]  = nrz[i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scrState <= '0;
      nrzState <= 1'b0;
    end else if (advance) begin
      scrState <= hist[WORD_W];
      nrzState <= nrz[WORD_W];
    end
  end

endmodule

// File: rtl/sdi_enc_datapath.sv
module sdi_enc_datapath
  import sdi_enc_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int TAP_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] dataIn,
  input  inStrobe_t         inNow,
  input  outStrobe_t        stage1,
  output logic [WORD_W-1:0] dataOut,
  output logic              trsDetN
);

  localparam int HI_W = WORD_W - 2;

  logic [WORD_W-1:0] inReg;
  logic [WORD_W-1:0] filtWord;
  logic [WORD_W-1:0] codedWord;
  logic [WORD_W-1:0] nextOut;
  logic              scrAdvance;

  function automatic logic isRefCode(input logic [WORD_W-1:0] w);
    return (w[WORD_W-1:2] == '0) || (w[WORD_W-1:2] == {HI_W{1'b1}});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      inReg   <= '0;
      trsDetN <= 1'b1;
    end else begin
      if (inNow.load) inReg <= dataIn;
      trsDetN <= !(inNow.load && inNow.video && isRefCode(dataIn));
    end
  end

  // Low-bit cleanup: force the two LSBs to match the upper bits
  always_comb begin
    filtWord = inReg;
    if (stage1.filtOn && isRefCode(inReg))
      filtWord[1:0] = {2{inReg[WORD_W-1]}};
  end

  assign scrAdvance = stage1.valid && stage1.video && !stage1.bypass;

  sdi_enc_scrnrzi #(
    .WORD_W (WORD_W),
    .SCR_LEN(SCR_LEN),
    .TAP_POS(TAP_POS)
  ) u_scrnrzi (
    .clk    (clk),
    .rst    (rst),
    .advance(scrAdvance),
    .wordIn (filtWord),
    .wordOut(codedWord)
  );

  always_comb begin
    if (stage1.video)
      nextOut = stage1.bypass ? inReg : codedWord;
    else
      nextOut = {inReg[WORD_W-1] & stage1.violOn, inReg[WORD_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)               dataOut <= '0;
    else if (stage1.valid) dataOut <= nextOut;
  end

endmodule

// File: rtl/sdi_word_encoder.sv
module sdi_word_encoder
  import sdi_enc_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int TAP_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              videoMode,
  input  logic              latchNowN,
  input  logic              latchNextN,
  input  logic              bypass,
  input  logic              filterEnN,
  input  logic              violEn,
  output logic [WORD_W-1:0] dataOut,
  output logic              trsDetN
);

  inStrobe_t  inNow;
  outStrobe_t stage1;

  sdi_enc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .videoMode (videoMode),
    .latchNowN (latchNowN),
    .latchNextN(latchNextN),
    .bypass    (bypass),
    .filterEnN (filterEnN),
    .violEn    (violEn),
    .inNow     (inNow),
    .stage1    (stage1)
  );

  sdi_enc_datapath #(
    .WORD_W (WORD_W),
    .SCR_LEN(SCR_LEN),
    .TAP_POS(TAP_POS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .inNow  (inNow),
    .stage1 (stage1),
    .dataOut(dataOut),
    .trsDetN(trsDetN)
  );

endmodule

// File: rtl/sdi_word_encoder_chk.sv
module sdi_word_encoder_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] dataIn,
  input logic              videoMode,
  input logic              latchNowN,
  input logic              latchNextN,
  input logic              bypass,
  input logic              violEn,
  input logic [WORD_W-1:0] dataOut,
  input logic              trsDetN
);

  logic refIn;
  assign refIn = (dataIn[WORD_W-1:2] == '0) || (&dataIn[WORD_W-1:2]);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dataOut == '0 && trsDetN));

  // R3
  trs_low_chk: assert property (@(posedge clk) disable iff (rst)
    (videoMode && refIn) |=> !trsDetN);

  // R3
  trs_high_chk: assert property (@(posedge clk) disable iff (rst)
    (videoMode && !refIn) |=> trsDetN);

  // R4
  trs_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    !videoMode |=> trsDetN);

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (videoMode && bypass) |=> ##1 (dataOut == $past(dataIn, 2)));

  // R11
  bcast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!videoMode && latchNowN && latchNextN && $past(latchNextN) && !$past(videoMode))
      |=> ##1 $stable(dataOut));

  // R12
  viol_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!videoMode && !violEn && !latchNowN) |=> ##1 !dataOut[WORD_W-1]);

endmodule

bind sdi_word_encoder sdi_word_encoder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dataIn    (dataIn),
  .videoMode (videoMode),
  .latchNowN (latchNowN),
  .latchNextN(latchNextN),
  .bypass    (bypass),
  .violEn    (violEn),
  .dataOut   (dataOut),
  .trsDetN   (trsDetN)
);

// File: tb/sdi_word_encoder_bench.sv
`timescale 1ns/1ps
module sdi_word_encoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] dataIn = '0;
  logic       videoMode = 1'b1;
  logic       latchNowN = 1'b1;
  logic       latchNextN = 1'b1;
  logic       bypass = 1'b0;
  logic       filterEnN = 1'b1;
  logic       violEn = 1'b0;
  logic [9:0] dataOut;
  logic       trsDetN;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdi_word_encoder u_sdi_word_encoder (
    .clk(clk), .rst(rst), .dataIn(dataIn), .videoMode(videoMode),
    .latchNowN(latchNowN), .latchNextN(latchNextN), .bypass(bypass),
    .filterEnN(filterEnN), .violEn(violEn), .dataOut(dataOut), .trsDetN(trsDetN)
  );

  // {bypass, filterEnN, word}
  localparam logic [11:0] VEC [16] = '{
    12'h000, 12'h002, 12'h3FD, 12'h7FE, 12'h401, 12'h600, 12'h155, 12'hBFC,
    12'h404, 12'h3FB, 12'hCAA, 12'h523, 12'h400, 12'h3FF, 12'h6C7, 12'h001
  };

  // Reference scrambler / NRZI history
  logic [8:0] mScr = '0;
  logic       mNrz = 1'b0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelWord(input logic [9:0] w, input logic byp, input logic filtN,
                           output logic [9:0] o);
    logic [9:0] f;
    logic s;
    if (byp) begin
      o = w;
      return;
    end
    f = w;
    if (!filtN && w < 10'h004) f = 10'h000;
    if (!filtN && w > 10'h3FB) f = 10'h3FF;
    for (int b = 0; b < 10; b++) begin
      s = f[b] ^ mScr[3] ^ mScr[8];
      mScr = {mScr[7:0], s};
      mNrz = mNrz ^ s;
      o[b] = mNrz;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [9:0] expPrev;
    logic [9:0] expCur;
    logic       refCode;

    expPrev = '0;
    tick(); tick(); tick();
    // R1 reset state
    chk("R1 dataOut", dataOut, 10'h000);
    chk("R1 trsDetN", {9'd0, trsDetN}, 10'h001);
    rst = 1'b0;

    // Video stream from the vector table: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < 16; v++) begin
      bypass    = VEC[v][11];
      filterEnN = VEC[v][10];
      dataIn    = VEC[v][9:0];
      tick();
      refCode = (VEC[v][9:2] == 8'h00) || (VEC[v][9:2] == 8'hFF);
      chk("R3 trsDetN", {9'd0, trsDetN}, {9'd0, !refCode});
      if (v > 0) chk("R2 R5 R6 R7 R8 dataOut", dataOut, expPrev);
      modelWord(VEC[v][9:0], VEC[v][11], VEC[v][10], expCur);
      expPrev = expCur;
    end
    bypass = 1'b1; dataIn = 10'h111;
    tick();
    chk("R2 R6 R7 last coded word", dataOut, expPrev);
    tick();
    chk("R8 bypass word", dataOut, 10'h111);

    // Broadcast mode
    videoMode = 1'b0; bypass = 1'b1; filterEnN = 1'b0; violEn = 1'b0;
    dataIn = 10'h003; latchNowN = 1'b0;
    tick();
    chk("R4 trsDetN high in broadcast", {9'd0, trsDetN}, 10'h001);
    latchNowN = 1'b1; dataIn = 10'h155;
    tick();
    chk("R9 R13 captured word unfiltered", dataOut, 10'h003);
    dataIn = 10'h2AA;
    tick(); tick();
    chk("R11 hold without strobe", dataOut, 10'h003);

    dataIn = 10'h3FF; violEn = 1'b1; latchNowN = 1'b0;
    tick();
    latchNowN = 1'b1;
    tick();
    chk("R12 violation bit passed", dataOut, 10'h3FF);
    violEn = 1'b0; latchNowN = 1'b0;
    tick();
    latchNowN = 1'b1;
    tick();
    chk("R12 violation bit forced low", dataOut, 10'h1FF);

    violEn = 1'b1; dataIn = 10'h0F0; latchNextN = 1'b0;
    tick();
    dataIn = 10'h30F; latchNextN = 1'b1;
    tick();
    dataIn = 10'h222;
    tick();
    chk("R10 deferred capture", dataOut, 10'h30F);
    tick();
    chk("R11 hold after deferred capture", dataOut, 10'h30F);

    // Back to video: history held across broadcast (R13 R6)
    videoMode = 1'b1; bypass = 1'b0; filterEnN = 1'b1; violEn = 1'b0;
    dataIn = 10'h155;
    tick();
    modelWord(10'h155, 1'b0, 1'b1, expCur);
    dataIn = 10'h200;
    tick();
    chk("R13 R6 history held over broadcast", dataOut, expCur);

    // Mid-stream reset clears history (R1)
    rst = 1'b1;
    tick();
    chk("R1 reset mid-stream dataOut", dataOut, 10'h000);
    chk("R1 reset mid-stream trsDetN", {9'd0, trsDetN}, 10'h001);
    rst = 1'b0; mScr = '0; mNrz = 1'b0;
    dataIn = 10'h3FE; filterEnN = 1'b0;
    tick();
    chk("R3 trsDetN after reset", {9'd0, trsDetN}, 10'h000);
    modelWord(10'h3FE, 1'b0, 1'b0, expCur);
    dataIn = 10'h204;
    tick();
    chk("R5 R1 filtered first word after reset", dataOut, expCur);
    chk("R3 trsDetN single pulse", {9'd0, trsDetN}, 10'h001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule